// File: doc/BRIEF.md
# I2C Bus Busy and Arbitration Monitor

This block sits beside a local I2C-style transmitter and watches the shared SDA and SCL lines. It keeps two flags for host software. The bus-busy flag rises when a START condition appears on the bus and falls when a STOP condition appears. The arbitration-lost flag records whether the local transmitter released SDA high while another device held it low. An arbitration-lost pulse marks each cycle in which that flag goes from 0 to 1.

Software controls the block through a three-bit write port. The bits enable the monitor, choose how often the arbitration flag is updated, and allow software to clear (but never set) the busy flag. In per-bit mode the arbitration flag is updated at every SCL rising edge. In per-byte mode, mismatches are collected over the byte and the flag is written when the external byte-boundary strobe arrives. The raw SDA and SCL lines pass through a synchronizer inside the block before any condition is detected.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A START condition (SDA goes from 1 to 0 while SCL is 1 in both the old and the new sample) sets busy_o to 1 while the monitor is enabled.
- R2: A STOP condition (SDA goes from 0 to 1 while SCL is 1 in both the old and the new sample) clears busy_o to 0 while the monitor is enabled. Any other change of SDA or SCL leaves busy_o unchanged.
- R3: A write with wr_data_i[2] = 0 clears busy_o. A write with wr_data_i[2] = 1 leaves busy_o unchanged. No write can set busy_o.
- R4: If a START or STOP takes effect in the same cycle as a software write, the bus event decides the new busy_o value.
- R5: The write port sets the enable bit from wr_data_i[0] and the per-byte select bit from wr_data_i[1]. Both take effect from the cycle after the write. With wr_data_i[1] = 0 (per-bit mode), every SCL rising edge sets arb_lost_o to 1 if sda_drive_i is 1 and the synchronized SDA is 0, and otherwise clears it to 0.
- R6: In per-byte mode (wr_data_i[1] = 1), arb_lost_o holds its value between byte strobes. At byte_end_i it becomes 1 if any SCL rising edge since the previous strobe showed a mismatch, and otherwise 0.
- R7: arb_pulse_o is 1 for exactly the one cycle in which arb_lost_o changes from 0 to 1, and 0 at all other times.
- R8: While the enable bit is 0, bus activity, SCL edges and byte strobes change neither flag. A software clear of busy still takes effect.
- R9: After reset, busy_o, arb_lost_o and arb_pulse_o are 0, the monitor is disabled, and per-bit mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | Raw SDA line level |
| scl_i | input | 1 | Raw SCL line level |
| sda_drive_i | input | 1 | Level the local transmitter puts on SDA (1 = released) |
| byte_end_i | input | 1 | One-cycle strobe marking the end of a byte |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 3 | Bit 0 enable, bit 1 per-byte select, bit 2 busy write (0 clears) |
| busy_o | output | 1 | Bus-busy flag |
| arb_lost_o | output | 1 | Arbitration-lost flag |
| arb_pulse_o | output | 1 | One-cycle pulse when arbitration is lost |

## Verification
A change on sda_i or scl_i passes two synchronizer flops and one history flop. Its effect on busy_o and arb_lost_o is therefore visible after the third rising clock edge that follows the change. The bench drives inputs on the falling edge and samples right after that third edge. A write or byte strobe that is held for one cycle acts at the next rising edge, so its result is sampled on the following falling edge. To check R4, the bench places the write in the cycle just before the edge at which the bus condition takes effect, so the two land on the same edge.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    // control word layout on the write port
    localparam int CTRL_W        = 3;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_BYTE_BIT = 1;
    localparam int CTRL_BUSY_BIT = 2;

    // number of synchronizer flops ahead of the condition detector
    localparam int SYNC_DEPTH = 2;

    typedef struct packed {
        logic en;
        logic per_byte;
    } ctrl_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    // the bus idles high, so every stage resets to ones
    localparam logic [WIDTH-1:0] IDLE = {WIDTH{1'b1}};

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= IDLE;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/i2cmon_cond_detect.sv
module i2cmon_cond_detect
    import i2cmon_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sda_s_i,
    input  logic    scl_s_i,
    output bus_ev_t ev_o
);

    typedef struct packed {
        logic sda;
        logic scl;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d.sda = sda_s_i;
        hist_d.scl = scl_s_i;

        ev_o.sda      = sda_s_i;
        ev_o.scl_rise = scl_s_i & ~hist_q.scl;
        // SCL must be high in both the old and the new sample
        ev_o.start    = scl_s_i & hist_q.scl &  hist_q.sda & ~sda_s_i;
        ev_o.stop     = scl_s_i & hist_q.scl & ~hist_q.sda &  sda_s_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '{sda: 1'b1, scl: 1'b1};
        else        hist_q <= hist_d;
    end

endmodule

// File: rtl/i2cmon_ctrl_busy.sv
module i2cmon_ctrl_busy
    import i2cmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  bus_ev_t           ev_i,
    output ctrl_t             ctrl_o,
    output logic              busy_o
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  busy;
    } cb_state_t;

    cb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // software first: it may change the mode and clear busy
        if (wr_en_i) begin
            st_d.ctrl.en       = wr_data_i[CTRL_EN_BIT];
            st_d.ctrl.per_byte = wr_data_i[CTRL_BYTE_BIT];
            if (!wr_data_i[CTRL_BUSY_BIT]) begin
                st_d.busy = 1'b0;
            end
        end

        // a bus event comes after the write, so it wins
        if (st_q.ctrl.en) begin
            if (ev_i.start) begin
                st_d.busy = 1'b1;
            end else if (ev_i.stop) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign busy_o = st_q.busy;

endmodule

// File: rtl/i2cmon_arb.sv
module i2cmon_arb
    import i2cmon_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ctrl_t   ctrl_i,
    input  bus_ev_t ev_i,
    input  logic    sda_drive_i,
    input  logic    byte_end_i,
    output logic    lost_o,
    output logic    pulse_o
);

    typedef struct packed {
        logic acc;
        logic lost;
        logic pulse;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic       mismatch;
    logic       acc_next;

    always_comb begin
        st_d     = st_q;
        mismatch = ev_i.scl_rise & sda_drive_i & ~ev_i.sda;
        acc_next = st_q.acc | mismatch;

        if (!ctrl_i.en) begin
            st_d.acc = 1'b0;
        end else if (!ctrl_i.per_byte) begin
            st_d.acc = 1'b0;
            if (ev_i.scl_rise) begin
                st_d.lost = mismatch;
            end
        end else begin
            if (byte_end_i) begin
                st_d.lost = acc_next;
                st_d.acc  = 1'b0;
            end else begin
                st_d.acc  = acc_next;
            end
        end

        st_d.pulse = st_d.lost & ~st_q.lost;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lost_o  = st_q.lost;
    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2cmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_i,
    input  logic              sda_drive_i,
    input  logic              byte_end_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic              busy_o,
    output logic              arb_lost_o,
    output logic              arb_pulse_o
);

    logic [1:0] line_s;
    bus_ev_t    ev;
    ctrl_t      ctrl;

    i2cmon_sync #(
        .STAGES (SYNC_DEPTH),
        .WIDTH  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sda_i, scl_i}),
        .q_o   (line_s)
    );

    i2cmon_cond_detect u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .sda_s_i (line_s[1]),
        .scl_s_i (line_s[0]),
        .ev_o    (ev)
    );

    i2cmon_ctrl_busy u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .ev_i      (ev),
        .ctrl_o    (ctrl),
        .busy_o    (busy_o)
    );

    i2cmon_arb u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_i      (ctrl),
        .ev_i        (ev),
        .sda_drive_i (sda_drive_i),
        .byte_end_i  (byte_end_i),
        .lost_o      (arb_lost_o),
        .pulse_o     (arb_pulse_o)
    );

endmodule

// File: rtl/i2cmon_chk.sv
module i2cmon_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       per_byte,
    input logic       start,
    input logic       stop,
    input logic       byte_end_i,
    input logic       wr_en_i,
    input logic [2:0] wr_data_i,
    input logic       busy_o,
    input logic       arb_lost_o,
    input logic       arb_pulse_o
);

    // R1
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && start) |=> busy_o);

    // R2
    stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stop) |=> !busy_o);

    // R3
    busy_rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(en && start));

    // R6
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && per_byte && !byte_end_i) |=> $stable(arb_lost_o));

    // R7
    pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_pulse_o |-> (arb_lost_o && !$past(arb_lost_o)));

    // R8
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !(wr_en_i && !wr_data_i[2])) |=> ($stable(busy_o) && $stable(arb_lost_o)));

endmodule

bind i2c_bus_monitor i2cmon_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (ctrl.en),
    .per_byte    (ctrl.per_byte),
    .start       (ev.start),
    .stop        (ev.stop),
    .byte_end_i  (byte_end_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .busy_o      (busy_o),
    .arb_lost_o  (arb_lost_o),
    .arb_pulse_o (arb_pulse_o)
);

// File: tb/i2c_bus_monitor_test.sv
module i2c_bus_monitor_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sda_i = 1'b1;
    logic       scl_i = 1'b1;
    logic       sda_drive_i = 1'b1;
    logic       byte_end_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_data_i = 3'b000;
    logic       busy_o, arb_lost_o, arb_pulse_o;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic m_en = 1'b0, m_byte = 1'b0, m_busy = 1'b0, m_lost = 1'b0, m_acc = 1'b0;
    logic p_sda = 1'b1, p_scl = 1'b1;

    always #2 clk = ~clk;

    i2c_bus_monitor uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_i       (sda_i),
        .scl_i       (scl_i),
        .sda_drive_i (sda_drive_i),
        .byte_end_i  (byte_end_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .busy_o      (busy_o),
        .arb_lost_o  (arb_lost_o),
        .arb_pulse_o (arb_pulse_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // drive lines, let three edges pass, return on the falling edge after them
    task automatic bus(input logic sda, input logic scl, input string req);
        logic old_lost;
        logic mis;
        logic rise;
        old_lost = m_lost;
        @(negedge clk);
        sda_i = sda;
        scl_i = scl;
        rise = scl & ~p_scl;
        mis  = rise & sda_drive_i & ~sda;
        if (m_en) begin
            if (scl && p_scl && p_sda && !sda)      m_busy = 1'b1;
            else if (scl && p_scl && !p_sda && sda) m_busy = 1'b0;
            if (!m_byte) begin
                if (rise) m_lost = mis;
            end else begin
                m_acc = m_acc | mis;
            end
        end
        p_sda = sda;
        p_scl = scl;
        repeat (2) @(negedge clk);
        // change is visible after the third rising edge
        @(negedge clk);
        chk(req, busy_o, m_busy);
        chk(req, arb_lost_o, m_lost);
        chk({req, " pulse"}, arb_pulse_o, m_lost & ~old_lost);
    endtask

    task automatic wr(input logic [2:0] d);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        if (!d[2]) m_busy = 1'b0;
        m_en   = d[0];
        m_byte = d[1];
        m_acc  = 1'b0;
    endtask

    task automatic strobe(input string req);
        logic old_lost;
        old_lost = m_lost;
        @(negedge clk);
        byte_end_i = 1'b1;
        @(negedge clk);
        byte_end_i = 1'b0;
        if (m_en && m_byte) begin
            m_lost = m_acc;
            m_acc  = 1'b0;
        end
        chk(req, arb_lost_o, m_lost);
        chk({req, " pulse"}, arb_pulse_o, m_lost & ~old_lost);
    endtask

    // one data bit: SCL low, set SDA and drive, raise SCL, lower SCL
    task automatic bit_cycle(input logic drv, input logic sda, input string req);
        bus(p_sda, 1'b0, req);
        sda_drive_i = drv;
        bus(sda, 1'b0, req);
        bus(sda, 1'b1, req);
        bus(sda, 1'b0, req);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 busy", busy_o, 1'b0);
        chk("R9 lost", arb_lost_o, 1'b0);
        chk("R9 pulse", arb_pulse_o, 1'b0);
        // R9/R8 disabled after reset: a START is ignored
        bus(1'b0, 1'b1, "R8 start while disabled");
        chk("R8 busy held", busy_o, 1'b0);
        bus(1'b1, 1'b1, "R8 stop while disabled");

        wr(3'b101);  // enable, per-bit, busy write 1

        // R1 R2: every pair of line states, twice around
        for (int rep = 0; rep < 2; rep++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    bus(a[1], a[0], "R1 R2 sweep from");
                    bus(b[1], b[0], "R1 R2 sweep to");
                end
            end
        end

        // R3: write of 1 has no effect, write of 0 clears
        bus(1'b1, 1'b1, "R3 idle");
        bus(1'b0, 1'b1, "R3 start");
        chk("R3 busy set", busy_o, 1'b1);
        wr(3'b101);
        chk("R3 write1 keeps", busy_o, 1'b1);
        wr(3'b001);
        chk("R3 write0 clears", busy_o, 1'b0);

        // R4: write 0 lands on the same edge as a START
        bus(1'b1, 1'b1, "R4 idle");
        @(negedge clk);
        sda_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_en_i = 1'b1; wr_data_i = 3'b001;
        @(negedge clk);
        wr_en_i = 1'b0;
        chk("R4 start beats clear", busy_o, 1'b1);
        m_busy = 1'b1; p_sda = 1'b0;
        // STOP beats a write of 1 (which would not set anyway) and a write of 0
        @(negedge clk);
        sda_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en_i = 1'b1; wr_data_i = 3'b101;
        @(negedge clk);
        wr_en_i = 1'b0;
        chk("R4 stop wins", busy_o, 1'b0);
        m_busy = 1'b0; p_sda = 1'b1;
        @(negedge clk);

        // R5 per-bit: all drive/sda pairs, twice
        for (int rep = 0; rep < 2; rep++) begin
            for (int k = 0; k < 4; k++) begin
                bit_cycle(k[1], k[0], "R5 per-bit");
            end
        end
        bit_cycle(1'b1, 1'b0, "R5 set");
        bit_cycle(1'b1, 1'b1, "R5 clear on match");

        // R6 R7 per-byte: every 4-bit mismatch mask
        wr(3'b011);
        for (int mask = 0; mask < 16; mask++) begin
            for (int i = 0; i < 4; i++) begin
                bit_cycle(1'b1, ~mask[i], "R6 hold in byte");
            end
            strobe("R6 R7 byte result");
        end

        // R8: disabled holds both flags
        bit_cycle(1'b1, 1'b0, "R8 prep");
        strobe("R8 prep");
        wr(3'b110);
        bit_cycle(1'b1, 1'b1, "R8 bit ignored");
        strobe("R8 strobe ignored");
        chk("R8 lost held", arb_lost_o, 1'b1);
        bus(1'b1, 1'b1, "R8 idle");
        bus(1'b0, 1'b1, "R8 start ignored");
        chk("R8 busy held", busy_o, 1'b0);

        finish_run();
    end

endmodule